// File: doc/BRIEF.md
# FIFO Fill-Level DMA Request and Interrupt Generator

This block watches the fill counts of a transmit FIFO and a receive FIFO and turns them into two DMA request lines, two level interrupts and an idle-line receive timeout flag. The FIFO storage and the serial shifters live elsewhere. The block sees only the counts, a few control bits, a once-per-character tick and one strobe each for a received character and a host read.

Two signalling styles are available. Single-transfer style asks for one character at a time. Block style asks for a burst once a programmable threshold is crossed. It then keeps the request up until the FIFO is drained (receive) or filled (transmit), so a DMA engine can move a whole block without the request toggling. Thresholds come from 4-bit fields scaled by four. A zero field selects a fixed default level.

Top module: `fifo_dma_status`

## Requirements
- R1: While reset is asserted and on the first clock after it, `tx_rdy`, `rx_rdy`, `rx_lvl_irq`, `tx_lvl_irq` and `rx_idle` are all 0.
- R2: Block style is in force only when `fifo_on`=1 and `blk_mode`=1. Otherwise single-transfer style applies. In that style `rx_rdy` is 1 exactly when `rx_fill` is not 0, and `tx_rdy` is 1 exactly when `tx_fill` is 0.
- R3: A threshold field value n in 1..15 selects the level 4*n. The value 0 selects the default level, which is 8 for transmit and 1 for receive with default parameters.
- R4: In block style, `rx_rdy` goes to 1 when `rx_fill` is at least the receive level. It then stays at 1, even while the fill is below the level, until `rx_fill` is 0.
- R5: In block style, `tx_rdy` goes to 1 when the free space (64 - `tx_fill`) is at least the transmit level. It then stays at 1 until `tx_fill` is 64.
- R6: `rx_lvl_irq` is 1 when `rx_fill` is at least the receive level if `fifo_on`=1. It is 1 when `rx_fill` is not 0 if `fifo_on`=0.
- R7: `tx_lvl_irq` is 1 when the free space is at least the transmit level if `fifo_on`=1. It is 1 when `tx_fill` is 0 if `fifo_on`=0.
- R8: With `rx_fill` not 0 and no `rx_push`/`rx_pop`, `rx_idle` goes to 1 after 4 `char_tick` pulses and stays at 1.
- R9: An `rx_push` or `rx_pop` clears `rx_idle` and restarts the count of ticks from zero.
- R10: While `rx_fill` is 0, ticks are not counted and `rx_idle` is 0.
- R11: Every output is registered. It reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_on | input | 1 | FIFOs enabled |
| blk_mode | input | 1 | 1 selects block DMA style |
| tx_fill | input | 7 | Entries held in transmit FIFO (0..64) |
| rx_fill | input | 7 | Entries held in receive FIFO (0..64) |
| tx_thr | input | 4 | Transmit threshold field |
| rx_thr | input | 4 | Receive threshold field |
| char_tick | input | 1 | One-cycle pulse per character time |
| rx_push | input | 1 | A character was written into the receive FIFO |
| rx_pop | input | 1 | Host read a character from the receive FIFO |
| tx_rdy | output | 1 | Transmit DMA request |
| rx_rdy | output | 1 | Receive DMA request |
| rx_lvl_irq | output | 1 | Receive fill reached threshold |
| tx_lvl_irq | output | 1 | Transmit space reached threshold |
| rx_idle | output | 1 | Receive idle timeout |

## Verification
The bench builds the block with its defaults: a depth of 64, 4-bit fields with a step of 4, default levels of 8 and 1, and a four-character timeout. With these values the fill counts reach both ends of their range, 0 and 64. The extreme field values 1, 2, 15 and 0 can be driven, and the fill can sit just below and exactly at a threshold in both directions. The short timeout lets a full expiry, a restart by a host read, a restart by an arriving character and the clear on an emptied FIFO all fit in a few dozen cycles.

// File: rtl/fifo_dma_pkg.sv
`timescale 1ns/1ps
// Shared types for the FIFO DMA request logic.
// Assumes nothing beyond IEEE 1800-2017 packages.
package fifo_dma_pkg;
    // DMA signalling style as seen by the request generator
    typedef enum logic {
        DMA_SINGLE = 1'b0,
        DMA_BLOCK  = 1'b1
    } dma_style_e;
endpackage

// File: rtl/trig_level_sel.sv
`timescale 1ns/1ps
// Turns a threshold field into an entry-count level.
// A zero field maps to DEF_LVL, any other field to field*STEP.
// Assumes CNT_W is wide enough to hold (2**FLD_W - 1)*STEP.
module trig_level_sel #(
    parameter int CNT_W   = 7,
    parameter int FLD_W   = 4,
    parameter int STEP    = 4,
    parameter int DEF_LVL = 8
) (
    input  logic [FLD_W-1:0] fld,
    output logic [CNT_W-1:0] lvl
);
    // Field decode into a level
    always_comb begin
        if (fld == '0) lvl = CNT_W'(DEF_LVL);
        else           lvl = CNT_W'(fld) * CNT_W'(STEP);
    end
endmodule

// File: rtl/dma_req_ctrl.sv
`timescale 1ns/1ps
// Registered DMA request and level-interrupt generation.
// In block style each request sets on its threshold and clears only at
// the far end (receive empty, transmit full). This gives hysteresis.
// Assumes fill counts never exceed DEPTH and levels are below DEPTH.
module dma_req_ctrl
    import fifo_dma_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dma_style_e       style,
    input  logic             fifo_on,
    input  logic [CNT_W-1:0] tx_fill,
    input  logic [CNT_W-1:0] rx_fill,
    input  logic [CNT_W-1:0] tx_lvl,
    input  logic [CNT_W-1:0] rx_lvl,
    output logic             tx_rdy,
    output logic             rx_rdy,
    output logic             tx_irq,
    output logic             rx_irq
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] tx_free;
    logic tx_space_hit, rx_fill_hit, tx_empty, rx_empty, tx_full;
    logic tx_rdy_d, rx_rdy_d, tx_irq_d, rx_irq_d;

    // Threshold comparisons shared by requests and interrupts
    always_comb begin
        tx_free      = FULL - tx_fill;
        tx_space_hit = (tx_free >= tx_lvl);
        rx_fill_hit  = (rx_fill >= rx_lvl);
        tx_empty     = (tx_fill == '0);
        rx_empty     = (rx_fill == '0);
        tx_full      = (tx_fill == FULL);
    end

    // Next-state of the request lines per signalling style
    always_comb begin
        if (style == DMA_BLOCK) begin
            if (rx_fill_hit)   rx_rdy_d = 1'b1;
            else if (rx_empty) rx_rdy_d = 1'b0;
            else               rx_rdy_d = rx_rdy;
            if (tx_space_hit)  tx_rdy_d = 1'b1;
            else if (tx_full)  tx_rdy_d = 1'b0;
            else               tx_rdy_d = tx_rdy;
        end else begin
            rx_rdy_d = !rx_empty;
            tx_rdy_d = tx_empty;
        end
    end

    // Level interrupts fall back to single-entry rules with FIFOs off
    always_comb begin
        rx_irq_d = fifo_on ? rx_fill_hit  : !rx_empty;
        tx_irq_d = fifo_on ? tx_space_hit : tx_empty;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_rdy <= 1'b0;
            rx_rdy <= 1'b0;
            tx_irq <= 1'b0;
            rx_irq <= 1'b0;
        end else begin
            tx_rdy <= tx_rdy_d;
            rx_rdy <= rx_rdy_d;
            tx_irq <= tx_irq_d;
            rx_irq <= rx_irq_d;
        end
    end
endmodule

// File: rtl/rx_idle_timer.sv
`timescale 1ns/1ps
// Receive idle timeout: counts character ticks while the receive FIFO
// holds data. It flags after IDLE_CHARS ticks with no push and no pop.
// Assumes char_tick is a single-cycle pulse per character time.
module rx_idle_timer #(
    parameter int IDLE_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic has_data,
    input  logic restart,
    input  logic char_tick,
    output logic idle
);
    localparam int TW = $clog2(IDLE_CHARS + 1);
    localparam logic [TW-1:0] LAST = TW'(IDLE_CHARS - 1);

    logic [TW-1:0] ticks;

    // Tick counter with restart and empty hold-off
    always_ff @(posedge clk) begin
        if (!rst_n || !has_data || restart) begin
            ticks <= '0;
            idle  <= 1'b0;
        end else if (char_tick && !idle) begin
            ticks <= ticks + 1'b1;
            if (ticks == LAST) idle <= 1'b1;
        end
    end
endmodule

// File: rtl/fifo_dma_status.sv
`timescale 1ns/1ps
// Top of the FIFO DMA request logic: decodes both thresholds, selects the
// signalling style, and combines request, interrupt and idle timer logic.
// Assumes fill counts are supplied by the FIFOs and stay within 0..DEPTH.
module fifo_dma_status
    import fifo_dma_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int FLD_W      = 4,
    parameter int STEP       = 4,
    parameter int TX_DEF_LVL = 8,
    parameter int RX_DEF_LVL = 1,
    parameter int IDLE_CHARS = 4,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_on,
    input  logic             blk_mode,
    input  logic [CNT_W-1:0] tx_fill,
    input  logic [CNT_W-1:0] rx_fill,
    input  logic [FLD_W-1:0] tx_thr,
    input  logic [FLD_W-1:0] rx_thr,
    input  logic             char_tick,
    input  logic             rx_push,
    input  logic             rx_pop,
    output logic             tx_rdy,
    output logic             rx_rdy,
    output logic             rx_lvl_irq,
    output logic             tx_lvl_irq,
    output logic             rx_idle
);
    localparam int N_DIR = 2; // index 0 transmit, 1 receive

    logic [FLD_W-1:0] fld [N_DIR];
    logic [CNT_W-1:0] lvl [N_DIR];
    dma_style_e       style;

    // Field routing per direction
    always_comb begin
        fld[0] = tx_thr;
        fld[1] = rx_thr;
    end

    // One level decoder per direction, each with its own default
    for (genvar d = 0; d < N_DIR; d++) begin : g_lvl
        trig_level_sel #(
            .CNT_W  (CNT_W),
            .FLD_W  (FLD_W),
            .STEP   (STEP),
            .DEF_LVL((d == 0) ? TX_DEF_LVL : RX_DEF_LVL)
        ) sel_i (
            .fld(fld[d]),
            .lvl(lvl[d])
        );
    end

    // Block style needs FIFOs on; otherwise single-transfer style
    always_comb style = (fifo_on && blk_mode) ? DMA_BLOCK : DMA_SINGLE;

    dma_req_ctrl #(
        .DEPTH(DEPTH),
        .CNT_W(CNT_W)
    ) req_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .style  (style),
        .fifo_on(fifo_on),
        .tx_fill(tx_fill),
        .rx_fill(rx_fill),
        .tx_lvl (lvl[0]),
        .rx_lvl (lvl[1]),
        .tx_rdy (tx_rdy),
        .rx_rdy (rx_rdy),
        .tx_irq (tx_lvl_irq),
        .rx_irq (rx_lvl_irq)
    );

    rx_idle_timer #(
        .IDLE_CHARS(IDLE_CHARS)
    ) idle_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .has_data (rx_fill != '0),
        .restart  (rx_push || rx_pop),
        .char_tick(char_tick),
        .idle     (rx_idle)
    );
endmodule

// File: rtl/fifo_dma_status_chk.sv
`timescale 1ns/1ps
// Property checker for fifo_dma_status, attached by bind below.
module fifo_dma_status_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_on,
    input logic             blk_mode,
    input logic [CNT_W-1:0] tx_fill,
    input logic [CNT_W-1:0] rx_fill,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             tx_rdy,
    input logic             rx_rdy,
    input logic             rx_idle
);
    logic blk;
    always_comb blk = fifo_on && blk_mode;

    // R2: single style, data present raises the receive request
    p_single_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk && rx_fill != '0) |=> rx_rdy);

    // R2: single style, non-empty transmit FIFO drops the transmit request
    p_single_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk && tx_fill != '0) |=> !tx_rdy);

    // R4: block style, receive request holds while data remains
    p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && rx_rdy && rx_fill != '0) |=> rx_rdy);

    // R5: block style, full transmit FIFO drops the request
    p_tx_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && tx_fill == CNT_W'(DEPTH)) |=> !tx_rdy);

    // R9: push or pop clears the idle flag
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_pop) |=> !rx_idle);

    // R10: empty receive FIFO keeps idle low
    p_empty_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fill == '0) |=> !rx_idle);
endmodule

bind fifo_dma_status fifo_dma_status_chk #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_on (fifo_on),
    .blk_mode(blk_mode),
    .tx_fill (tx_fill),
    .rx_fill (rx_fill),
    .rx_push (rx_push),
    .rx_pop  (rx_pop),
    .tx_rdy  (tx_rdy),
    .rx_rdy  (rx_rdy),
    .rx_idle (rx_idle)
);

// File: tb/fifo_dma_status_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one cycle of stimulus and pushes the
// expected outputs. The monitor pops and compares after the next rising edge.
module fifo_dma_status_tb_top;
    localparam int DEPTH = 64;
    localparam int CNT_W = 7;

    typedef struct {
        logic  tx_rdy, rx_rdy, rx_irq, tx_irq, idle;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_on = 1'b0, blk_mode = 1'b0;
    logic [CNT_W-1:0] tx_fill = '0, rx_fill = '0;
    logic [3:0] tx_thr = '0, rx_thr = '0;
    logic char_tick = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic tx_rdy, rx_rdy, rx_lvl_irq, tx_lvl_irq, rx_idle;

    int n_cmp = 0;
    int n_bad = 0;
    exp_t sb[$];

    // Reference state built from the requirements
    logic m_tx = 0, m_rx = 0, m_idle = 0;
    int   m_ticks = 0;

    always #10 clk = ~clk; // 50 MHz

    fifo_dma_status dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .blk_mode(blk_mode),
        .tx_fill(tx_fill), .rx_fill(rx_fill), .tx_thr(tx_thr), .rx_thr(rx_thr),
        .char_tick(char_tick), .rx_push(rx_push), .rx_pop(rx_pop),
        .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .rx_lvl_irq(rx_lvl_irq),
        .tx_lvl_irq(tx_lvl_irq), .rx_idle(rx_idle)
    );

    function automatic int lvl_of(input logic [3:0] f, input int def);
        return (f == 0) ? def : 4 * int'(f); // R3
    endfunction

    task automatic check1(input string tag, input string what, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %b expected %b", tag, what, got, exp);
        end
    endtask

    // Monitor: compares after each rising edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check1(e.tag, "tx_rdy",     tx_rdy,     e.tx_rdy);
            check1(e.tag, "rx_rdy",     rx_rdy,     e.rx_rdy);
            check1(e.tag, "rx_lvl_irq", rx_lvl_irq, e.rx_irq);
            check1(e.tag, "tx_lvl_irq", tx_lvl_irq, e.tx_irq);
            check1(e.tag, "rx_idle",    rx_idle,    e.idle);
        end
    end

    // Driver: one cycle of stimulus plus the expected result
    task automatic step(input string tag, input logic fo, input logic bm,
                        input int txf, input int rxf, input logic [3:0] tt,
                        input logic [3:0] rt, input logic tk, input logic ps,
                        input logic pp);
        exp_t e;
        int tl, rl, free;
        logic blk;
        @(negedge clk);
        fifo_on = fo; blk_mode = bm; tx_fill = CNT_W'(txf); rx_fill = CNT_W'(rxf);
        tx_thr = tt; rx_thr = rt; char_tick = tk; rx_push = ps; rx_pop = pp;
        tl = lvl_of(tt, 8);
        rl = lvl_of(rt, 1);
        free = DEPTH - txf;
        blk = fo && bm;
        if (blk) begin
            if (rxf >= rl) m_rx = 1; else if (rxf == 0) m_rx = 0;
            if (free >= tl) m_tx = 1; else if (txf == DEPTH) m_tx = 0;
        end else begin
            m_rx = (rxf != 0);
            m_tx = (txf == 0);
        end
        if (rxf == 0 || ps || pp) begin
            m_ticks = 0; m_idle = 0;
        end else if (tk && !m_idle) begin
            m_ticks++;
            if (m_ticks == 4) m_idle = 1;
        end
        e.tx_rdy = m_tx;
        e.rx_rdy = m_rx;
        e.rx_irq = fo ? (rxf >= rl) : (rxf != 0);
        e.tx_irq = fo ? (free >= tl) : (txf == 0);
        e.idle   = m_idle;
        e.tag    = tag;
        sb.push_back(e);
    endtask

    initial begin
        // R1: outputs quiet in reset
        repeat (3) @(negedge clk);
        tx_fill = 7'd0; rx_fill = 7'd5; fifo_on = 1; // would raise outputs if not in reset
        @(negedge clk);
        check1("R1", "tx_rdy", tx_rdy, 1'b0);
        check1("R1", "rx_rdy", rx_rdy, 1'b0);
        check1("R1", "rx_lvl_irq", rx_lvl_irq, 1'b0);
        check1("R1", "tx_lvl_irq", tx_lvl_irq, 1'b0);
        check1("R1", "rx_idle", rx_idle, 1'b0);
        rst_n = 1'b1;

        // R2 R11: single style with FIFOs on
        step("R2", 1, 0, 0, 0, 1, 1, 0, 0, 0);
        step("R2", 1, 0, 3, 1, 1, 1, 0, 0, 0);
        step("R2", 1, 0, 0, 5, 1, 1, 0, 0, 0);
        step("R11", 1, 0, 64, 0, 1, 1, 0, 0, 0);
        // R2 R6 R7: FIFOs off forces single style even with block bit
        step("R2", 0, 1, 0, 1, 15, 15, 0, 0, 0);
        step("R6", 0, 1, 5, 0, 15, 15, 0, 0, 0);
        step("R7", 0, 1, 0, 2, 15, 15, 0, 0, 0);

        // R4 R3 R6: block receive with field 2 (level 8)
        step("R4", 1, 1, 64, 0, 2, 2, 0, 0, 0);
        step("R4", 1, 1, 64, 7, 2, 2, 0, 0, 0);
        step("R4", 1, 1, 64, 8, 2, 2, 0, 0, 0);
        step("R4", 1, 1, 64, 3, 2, 2, 0, 0, 0);
        step("R4", 1, 1, 64, 1, 2, 2, 0, 0, 0);
        step("R4", 1, 1, 64, 0, 2, 2, 0, 0, 0);
        step("R6", 1, 1, 64, 7, 2, 2, 0, 0, 0);

        // R5 R3 R7: block transmit with field 15 (level 60)
        step("R5", 1, 1, 10, 0, 15, 15, 0, 0, 0);
        step("R5", 1, 1, 4, 0, 15, 15, 0, 0, 0);
        step("R5", 1, 1, 40, 0, 15, 15, 0, 0, 0);
        step("R5", 1, 1, 63, 0, 15, 15, 0, 0, 0);
        step("R5", 1, 1, 64, 0, 15, 15, 0, 0, 0);
        step("R5", 1, 1, 40, 0, 15, 15, 0, 0, 0);
        step("R7", 1, 1, 0, 0, 15, 15, 0, 0, 0);
        // R3: field 1 gives level 4
        step("R3", 1, 1, 64, 3, 1, 1, 0, 0, 0);
        step("R3", 1, 1, 61, 4, 1, 1, 0, 0, 0);
        step("R3", 1, 1, 60, 4, 1, 1, 0, 0, 0);

        // R3: zero fields select defaults (tx 8, rx 1)
        step("R3", 1, 1, 64, 0, 0, 0, 0, 0, 0);
        step("R3", 1, 1, 57, 1, 0, 0, 0, 0, 0);
        step("R3", 1, 1, 56, 1, 0, 0, 0, 0, 0);

        // R8: timeout after four ticks with data present
        step("R8", 1, 0, 0, 3, 1, 1, 0, 1, 0);
        step("R8", 1, 0, 0, 3, 1, 1, 1, 0, 0);
        step("R8", 1, 0, 0, 3, 1, 1, 0, 0, 0);
        step("R8", 1, 0, 0, 3, 1, 1, 1, 0, 0);
        step("R8", 1, 0, 0, 3, 1, 1, 1, 0, 0);
        step("R8", 1, 0, 0, 3, 1, 1, 0, 0, 0);
        step("R8", 1, 0, 0, 3, 1, 1, 1, 0, 0);
        step("R8", 1, 0, 0, 3, 1, 1, 1, 0, 0);
        // R9: a host read clears and restarts
        step("R9", 1, 0, 0, 2, 1, 1, 0, 0, 1);
        step("R9", 1, 0, 0, 2, 1, 1, 1, 0, 0);
        step("R9", 1, 0, 0, 2, 1, 1, 1, 0, 0);
        step("R9", 1, 0, 0, 2, 1, 1, 1, 0, 0);
        step("R9", 1, 0, 0, 3, 1, 1, 1, 1, 0); // push with tick: restart wins
        step("R9", 1, 0, 0, 3, 1, 1, 1, 0, 0);
        step("R9", 1, 0, 0, 3, 1, 1, 1, 0, 0);
        step("R9", 1, 0, 0, 3, 1, 1, 1, 0, 0);
        step("R9", 1, 0, 0, 3, 1, 1, 1, 0, 0);
        // R10: empty FIFO clears and ignores ticks
        step("R10", 1, 0, 0, 0, 1, 1, 1, 0, 0);
        step("R10", 1, 0, 0, 0, 1, 1, 1, 0, 0);
        step("R10", 1, 0, 0, 0, 1, 1, 1, 0, 0);
        step("R10", 1, 0, 0, 0, 1, 1, 1, 0, 0);
        step("R10", 1, 0, 0, 0, 1, 1, 1, 0, 0);
        step("R10", 1, 0, 0, 1, 1, 1, 0, 0, 0);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired got running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule